// File: doc/BRIEF.md
# Fixed-Latency Parallel Bus Slave Bridge

This block turns accesses from an external synchronous parallel memory bus into single-cycle accesses on a simple internal register bus. On the external side it sees a 24-bit address, a 32-bit bidirectional data bus and active-low select, address-latch, write-enable and output-enable strobes. It also has an active-low wait output. On the internal side it presents an address, a write strobe with its data, and a read strobe, and it takes back registered read data.

Every transfer has a fixed length, counted in rising clock edges from the edge that captures the address. The host drives its signals on falling edges, and the block samples them on rising edges. There is no handshake on either side and no back-pressure. The host cannot be stalled, so the wait output never asserts. The internal register bus must accept a write strobe in any cycle. It must return read data exactly one clock after a read strobe. The block meets the host's timing by issuing its internal strobes at fixed edge offsets.

Edge numbering: E0 is the rising edge at which select and address latch are both sampled low. Ek is the k-th rising edge after E0.

Top module: `pbus_bridge`

## Requirements
- R1: While reset is low and after it is released with no transfer, `reg_wr` and `reg_rd` are 0, `bus_wait_n` is 1 and the block does not drive `bus_data`.
- R2: The address on `bus_addr` at E0 appears on `reg_addr` after E0 and stays there while the strobes of that transfer are issued. Address-line values after E0 have no effect.
- R3: In a write (`bus_we_n` low at E0), `reg_wr` is 1 for exactly the one cycle between E4 and E5. During that cycle `reg_wdata` equals the value on `bus_data` at E4.
- R4: In a read (`bus_we_n` high at E0), `reg_rd` is 1 for exactly the one cycle between E1 and E2, with the captured address on `reg_addr`. A read never produces `reg_wr`, and a write never produces `reg_rd`.
- R5: The `reg_rdata` value sampled at E3 is driven on `bus_data` from then on, while select and output enable stay low. The host therefore reads it at E5.
- R6: While `bus_oe_n` is high, the block does not drive `bus_data`, and the host's value on the bus is unchanged.
- R7: `bus_wait_n` is always 1.
- R8: A rising edge that samples `bus_cs_n` high returns the sequencer to idle. A read whose select is high at E1 produces no `reg_rd`. A write whose select is high at or before E4 produces no `reg_wr`, and the addressed register keeps its value.
- R9: Each select-low period yields at most one transfer. A second address-latch pulse while select stays low is ignored, and no strobe repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the external bus |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | External address, valid at E0 only |
| bus_data | inout | 32 | External bidirectional data |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_adv_n | input | 1 | Active-low address latch |
| bus_we_n | input | 1 | Active-low write enable |
| bus_oe_n | input | 1 | Active-low output enable |
| bus_wait_n | output | 1 | Active-low wait, held high |
| reg_addr | output | 24 | Internal address, captured at E0 |
| reg_wr | output | 1 | Internal single-cycle write strobe |
| reg_wdata | output | 32 | Internal write data |
| reg_rd | output | 1 | Internal single-cycle read strobe |
| reg_rdata | input | 32 | Internal read data, registered one clock after `reg_rd` |

## Verification
Back-to-back writes and reads go to directed addresses of all zeros and all ones and to random addresses. They are checked against a small register model, so a wrong write-data edge, a wrong address or a wrong read-latch edge shows up as a wrong read-back value. The data lines carry random junk before E4 and the address lines carry junk after E0. This separates sampling at the intended edge from sampling one edge early or late. Aborted reads and writes, and a write with a second address-latch pulse, are counted strobe by strobe. These counts separate a sequencer that returns to idle from one that keeps firing.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int WR_EDGE       = 4,
  parameter int RD_ISSUE_EDGE = 1,
  parameter int RD_LATCH_EDGE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic adv_n,
  input  logic we_n,
  output logic cap_addr,
  output logic cap_wdata,
  output logic fire_rd,
  output logic latch_rd,
  output logic rd_phase
);
  localparam int MAX_EDGE = (WR_EDGE > RD_LATCH_EDGE) ? WR_EDGE : RD_LATCH_EDGE;
  localparam int CNT_W    = $clog2(MAX_EDGE + 1) + 1;
  localparam logic [CNT_W-1:0] WR_CNT  = CNT_W'(WR_EDGE);
  localparam logic [CNT_W-1:0] RDI_CNT = CNT_W'(RD_ISSUE_EDGE);
  localparam logic [CNT_W-1:0] RDL_CNT = CNT_W'(RD_LATCH_EDGE);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             is_wr;
  logic             running;
  logic             last_edge;

  // cnt equals k when the coming rising edge is Ek
  assign cap_addr  = (state == SEQ_IDLE) && !cs_n && !adv_n;
  assign running   = (state == SEQ_RUN) && !cs_n;
  assign cap_wdata = running && is_wr && (cnt == WR_CNT);
  assign fire_rd   = running && !is_wr && (cnt == RDI_CNT);
  assign latch_rd  = running && !is_wr && (cnt == RDL_CNT);
  assign last_edge = is_wr ? cap_wdata : latch_rd;
  assign rd_phase  = (state != SEQ_IDLE) && !is_wr;

  always_ff @(posedge clk) begin
    if (!rst_n || cs_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (cap_addr) begin
            state <= SEQ_RUN;
            cnt   <= CNT_W'(1);
            is_wr <= !we_n;
          end
        end
        SEQ_RUN: begin
          if (last_edge) state <= SEQ_DONE;
          else           cnt   <= cnt + CNT_W'(1);
        end
        default: state <= SEQ_DONE;
      endcase
    end
  end
endmodule

// File: rtl/pbus_capture.sv
module pbus_capture #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_addr,
  input  logic          cap_wdata,
  input  logic          fire_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      if (cap_addr)  reg_addr  <= bus_addr;
      if (cap_wdata) reg_wdata <= bus_din;
      reg_wr <= cap_wdata;
      reg_rd <= fire_rd;
    end
  end
endmodule

// File: rtl/pbus_rdpath.sv
module pbus_rdpath #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_rd,
  input  logic          rd_phase,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] rd_q,
  output logic          rd_drive
);
  always_ff @(posedge clk) begin
    if (!rst_n)        rd_q <= '0;
    else if (latch_rd) rd_q <= reg_rdata;
  end

  assign rd_drive = rd_phase && !cs_n && !oe_n;
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge #(
  parameter int AW            = 24,
  parameter int DW            = 32,
  parameter int WR_EDGE       = 4,
  parameter int RD_ISSUE_EDGE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  inout  wire  [DW-1:0] bus_data,
  input  logic          bus_cs_n,
  input  logic          bus_adv_n,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  output logic          bus_wait_n,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);
  // internal response is registered: latch two edges after the strobe is issued
  localparam int RD_LATCH_EDGE = RD_ISSUE_EDGE + 2;

  logic          cap_addr, cap_wdata, fire_rd, latch_rd, rd_phase;
  logic [DW-1:0] rd_q;
  logic          rd_drive;
  logic [DW-1:0] bus_din;

  assign bus_din    = bus_data;
  assign bus_data   = rd_drive ? rd_q : {DW{1'bz}};
  assign bus_wait_n = 1'b1;

  pbus_seq #(
    .WR_EDGE(WR_EDGE), .RD_ISSUE_EDGE(RD_ISSUE_EDGE), .RD_LATCH_EDGE(RD_LATCH_EDGE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .adv_n(bus_adv_n), .we_n(bus_we_n),
    .cap_addr(cap_addr), .cap_wdata(cap_wdata), .fire_rd(fire_rd),
    .latch_rd(latch_rd), .rd_phase(rd_phase)
  );

  pbus_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
    .fire_rd(fire_rd), .bus_addr(bus_addr), .bus_din(bus_din),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd)
  );

  pbus_rdpath #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .latch_rd(latch_rd), .rd_phase(rd_phase),
    .cs_n(bus_cs_n), .oe_n(bus_oe_n), .reg_rdata(reg_rdata),
    .rd_q(rd_q), .rd_drive(rd_drive)
  );
endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_cs_n,
  input logic bus_we_n,
  input logic bus_oe_n,
  input logic reg_wr,
  input logic reg_rd,
  input logic rd_drive
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R3
  AST_WR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> $past(!bus_we_n)); // R3
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R4
  AST_RD_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |-> $past(bus_we_n)); // R4
  AST_NO_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) bus_oe_n |-> !rd_drive); // R6
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $past(bus_cs_n) |-> (!reg_wr && !reg_rd)); // R8
endmodule

bind pbus_bridge pbus_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
  .bus_oe_n(bus_oe_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .rd_drive(rd_drive)
);

// File: tb/pbus_bridge_test.sv
`timescale 1ns / 1ps
module pbus_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_cs_n = 1'b1, bus_adv_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
  logic [31:0] host_d = '0;
  wire  [31:0] bus_data;
  logic        bus_wait_n;
  logic [23:0] reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, wait_bad = 0;
  logic [31:0] dev_mem [8];
  logic [31:0] exp_mem [8];

  always #2.5 clk = ~clk;

  assign bus_data = bus_oe_n ? host_d : 32'bz;

  pbus_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
    .bus_wait_n(bus_wait_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // internal register device: registered read response
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) dev_mem[i] <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) dev_mem[reg_addr[2:0]] <= reg_wdata;
      if (reg_rd) reg_rdata <= dev_mem[reg_addr[2:0]];
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_wr) wr_cnt <= wr_cnt + 1;
      if (reg_rd) rd_cnt <= rd_cnt + 1;
      if (!bus_wait_n) wait_bad <= wait_bad + 1;
    end
  end

  function automatic int slot(input logic [23:0] a);
    return int'(a[2:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [23:0] a, input logic [31:0] d, input bit dup_adv);
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk); bus_cs_n = 0; bus_adv_n = 0; bus_we_n = 0; bus_addr = a; host_d = $urandom();
    @(negedge clk); bus_adv_n = 1; bus_addr = $urandom();
    @(negedge clk); if (dup_adv) begin bus_adv_n = 0; bus_addr = ~a; end
    @(negedge clk); bus_adv_n = 1; host_d = $urandom();
    @(negedge clk); host_d = d;
    @(negedge clk);
    chk(reg_wr == 1'b1, "R3 strobe after E4", 32'(reg_wr), 32'd1);
    chk(reg_wdata == d, "R3 write data", reg_wdata, d);
    chk(reg_addr == a, "R2 write address", 32'(reg_addr), 32'(a));
    chk(bus_data == d, "R6 bus not driven during write", bus_data, d);
    bus_cs_n = 1; bus_we_n = 1; host_d = $urandom();
    @(negedge clk);
    chk(reg_wr == 1'b0, "R3 single cycle", 32'(reg_wr), 32'd0);
    chk(wr_cnt == w0 + 1, dup_adv ? "R9 one write strobe" : "R3 one write strobe", wr_cnt, w0 + 1);
    chk(rd_cnt == r0, "R4 no read strobe in write", rd_cnt, r0);
    exp_mem[slot(a)] = d;
  endtask

  task automatic host_read(input logic [23:0] a);
    int w0, r0;
    logic [31:0] e;
    w0 = wr_cnt; r0 = rd_cnt; e = exp_mem[slot(a)];
    @(negedge clk); bus_cs_n = 0; bus_adv_n = 0; bus_we_n = 1; bus_addr = a; host_d = $urandom();
    @(negedge clk); bus_adv_n = 1; bus_addr = $urandom();
    chk(bus_data == host_d, "R6 bus released before oe", bus_data, host_d);
    @(negedge clk); bus_oe_n = 0;
    chk(reg_rd == 1'b1, "R4 read strobe after E1", 32'(reg_rd), 32'd1);
    chk(reg_addr == a, "R2 read address", 32'(reg_addr), 32'(a));
    @(negedge clk);
    chk(reg_rd == 1'b0, "R4 single cycle", 32'(reg_rd), 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk(bus_data == e, "R5 read data at host sample", bus_data, e);
    @(negedge clk);
    @(negedge clk); bus_cs_n = 1; bus_oe_n = 1;
    @(negedge clk);
    chk(rd_cnt == r0 + 1, "R4 one read strobe", rd_cnt, r0 + 1);
    chk(wr_cnt == w0, "R4 no write strobe in read", wr_cnt, w0);
  endtask

  task automatic abort_read(input logic [23:0] a);
    int r0;
    r0 = rd_cnt;
    @(negedge clk); bus_cs_n = 0; bus_adv_n = 0; bus_we_n = 1; bus_addr = a;
    @(negedge clk); bus_cs_n = 1; bus_adv_n = 1;
    repeat (4) @(negedge clk);
    chk(rd_cnt == r0, "R8 aborted read no strobe", rd_cnt, r0);
  endtask

  task automatic abort_write(input logic [23:0] a, input logic [31:0] d);
    int w0;
    w0 = wr_cnt;
    @(negedge clk); bus_cs_n = 0; bus_adv_n = 0; bus_we_n = 0; bus_addr = a;
    @(negedge clk); bus_adv_n = 1;
    @(negedge clk);
    @(negedge clk); bus_cs_n = 1; bus_we_n = 1; host_d = d;
    repeat (4) @(negedge clk);
    chk(wr_cnt == w0, "R8 aborted write no strobe", wr_cnt, w0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0042);
    for (int i = 0; i < 8; i++) exp_mem[i] = '0;
    host_d = 32'hA5A5_0F0F;
    repeat (4) @(negedge clk);
    chk(reg_wr == 0 && reg_rd == 0, "R1 strobes low in reset", {30'd0, reg_wr, reg_rd}, 32'd0);
    chk(bus_wait_n == 1'b1, "R1 wait high in reset", 32'(bus_wait_n), 32'd1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(reg_wr == 0 && reg_rd == 0, "R1 idle after reset", {30'd0, reg_wr, reg_rd}, 32'd0);
    chk(bus_data == host_d, "R1 bus released", bus_data, host_d);

    host_write(24'h000000, 32'hCCAA_5533, 0);
    host_write(24'hFFFFFF, 32'hEDCB_EDCB, 0);
    host_write(24'h223344, 32'h1234_5678, 0);
    host_read(24'h000000);
    host_read(24'hFFFFFF);
    host_read(24'h223344);
    host_write(24'h000000, 32'hFFFF_FFFF, 0);
    host_write(24'h000000, 32'h0000_0000, 0);
    host_read(24'h000000);

    abort_read(24'h000007);
    host_write(24'h000005, 32'h5555_AAAA, 0);
    abort_write(24'h000005, 32'hDEAD_BEEF);
    host_read(24'h000005);          // R8 register kept its value
    host_write(24'h000006, 32'h0BAD_F00D, 1);
    host_read(24'h000006);          // R9 data landed once at first address
    host_read(~24'h000006);

    for (int n = 0; n < 60; n++) begin
      logic [23:0] a;
      int sel;
      sel = int'($urandom() % 6);
      a = (sel == 0) ? 24'h000000 : (sel == 1) ? 24'hFFFFFF : 24'($urandom());
      if ($urandom() % 2 == 0) host_write(a, $urandom(), 0);
      else                     host_read(a);
    end

    chk(wait_bad == 0, "R7 wait always high", wait_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule